// File: doc/BRIEF.md
# I2C EEPROM Slave Protocol Engine

This block is the bus-facing half of a 2048-byte serial EEPROM model. It runs on a system clock at least eight times faster than SCL and oversamples both bus lines. It recognises START and STOP conditions and accepts a slave byte whose top nibble must be `1010`. In a write, the three bits below that nibble carry the upper bits of an 11-bit memory pointer. The engine drives SDA only through an open-drain pull-down enable.

In write mode the engine takes a word-address byte that supplies the low eight pointer bits. It then accepts any number of data bytes and hands each one to a page buffer as a write request. Only a STOP after at least one data byte asks for the page to be programmed. In read mode it serves bytes from a combinational memory read port. These cover current-address reads, random reads (a dummy write followed by a repeated START) and sequential reads. One pointer is shared by reads and writes and persists between transactions. While the storage array reports a write cycle in progress, slave bytes are not acknowledged, so a host can poll for completion.

Top module: `i2c_eeprom_slave_fe`

## Requirements
- R1: While reset is asserted and just after it is released, `sda_pull`, `wr_req` and `wr_commit` are all 0.
- R2: A START seen at any point, including part-way through a byte, abandons the transfer in progress. The engine then waits for a new slave byte, and write bytes not yet followed by STOP are not committed.
- R3: A slave byte whose bits 7..4 (sent first) equal 1010 is acknowledged by holding SDA low through the ninth SCL pulse. Any other prefix gets no acknowledge, and the bus is ignored until the next START or STOP.
- R4: In a write (bit 0 = 0), slave-byte bits 3..1 load pointer bits 10..8 and the next byte loads pointer bits 7..0. Each later byte is acknowledged and raises `wr_req` for one cycle, with `wr_addr` set to the pointer and `wr_data` set to the byte.
- R5: After each write data byte only pointer bits 3..0 advance, wrapping within the 16-byte page. Bits 10..4 stay fixed.
- R6: `wr_commit` pulses for one cycle on a STOP only if the transaction delivered at least one data byte. A STOP right after the word address commits nothing.
- R7: A read (bit 0 = 1) ignores slave-byte bits 3..1 and returns the byte at the pointer. This is the location after the last byte read or written.
- R8: A word-address write followed by a repeated START and a read returns the byte at that word address.
- R9: Each byte the master acknowledges is followed by the byte at the next address. The full 11-bit pointer wraps from 0x7FF to 0x000.
- R10: After the master leaves the ninth bit of a read byte high (no acknowledge), the engine keeps SDA released until the next START or STOP.
- R11: While `wr_busy` is high a matching slave byte is not acknowledged. Once `wr_busy` is low it is acknowledged again.
- R12: `sda_pull` changes only while SCL is low, and read data leaves MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (wired-AND of all drivers) |
| wr_busy | input | 1 | High while the array is programming a page |
| mem_rdata | input | 8 | Byte at `mem_raddr`, combinational |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| mem_raddr | output | 11 | Shared address pointer, drives the read port |
| wr_req | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 11 | Target address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle strobe to program the buffered page |

## Verification
Some properties are checked on every cycle: SDA changes only while SCL is low, no acknowledge follows a slave byte taken while the array was busy, the strobes last one cycle, a commit follows only a STOP, a START releases SDA, and a silenced engine never pulls SDA. Other behaviour can only be shown by the bench scenarios. These include the addresses and data carried by whole transactions, page wrap during writes, full-range wrap during sequential reads, a pointer that carries across transactions, and recovery from a byte abandoned halfway by a repeated START.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RXDEV,
        ST_RXWORD,
        ST_RXDATA,
        ST_TX,
        ST_HOLD
    } ee_state_e;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_bit
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl;
        logic [SYNC_STAGES-1:0] sda;
        logic                   scl_p;
        logic                   sda_p;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_s, sda_s;

    assign scl_s = s_q.scl[SYNC_STAGES-1];
    assign sda_s = s_q.sda[SYNC_STAGES-1];

    always_comb begin
        s_d       = s_q;
        s_d.scl   = {s_q.scl[SYNC_STAGES-2:0], scl_in};
        s_d.sda   = {s_q.sda[SYNC_STAGES-2:0], sda_in};
        s_d.scl_p = scl_s;
        s_d.sda_p = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    // Edges and bus conditions come from the synchronised copies only.
    assign scl_rise  = scl_s & ~s_q.scl_p;
    assign scl_fall  = ~scl_s & s_q.scl_p;
    assign bus_start = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign bus_stop  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;
    assign sda_bit   = sda_s;
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter int AW        = 11,
    parameter int DW        = 8,
    parameter int PAGE_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic          sda_bit,
    input  logic          wr_busy,
    input  logic [DW-1:0] mem_rdata,
    output logic          sda_pull,
    output logic [AW-1:0] mem_raddr,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_commit,
    output ee_state_e     st
);
    localparam int HI_BITS = AW - DW;
    localparam int CNTW    = $clog2(DW + 2);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DW);
    localparam logic [CNTW-1:0] ACK_END  = CNTW'(DW + 1);

    typedef struct packed {
        ee_state_e     st;
        logic [CNTW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [DW-1:0] tx;
        logic [AW-1:0] ptr;
        logic          mack;
        logic          pend;
        logic          pull;
        logic          wreq;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic          commit;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d        = c_q;
        c_d.wreq   = 1'b0;
        c_d.commit = 1'b0;
        if (bus_stop) begin
            c_d.commit = c_q.pend;
            c_d.pend   = 1'b0;
            c_d.st     = ST_IDLE;
            c_d.cnt    = '0;
            c_d.pull   = 1'b0;
        end else if (bus_start) begin
            c_d.st   = ST_RXDEV;
            c_d.cnt  = '0;
            c_d.pull = 1'b0;
            c_d.pend = 1'b0;
        end else if (scl_rise) begin
            if (c_q.cnt != ACK_END) c_d.cnt = c_q.cnt + 1'b1;
            if (c_q.cnt < LAST_BIT) c_d.sh = {c_q.sh[DW-2:0], sda_bit};
            if (c_q.st == ST_TX && c_q.cnt == LAST_BIT) c_d.mack = ~sda_bit;
        end else if (scl_fall) begin
            case (c_q.st)
                ST_RXDEV, ST_RXWORD, ST_RXDATA: begin
                    if (c_q.cnt == ACK_END) begin
                        c_d.pull = 1'b0;
                        c_d.cnt  = '0;
                    end else if (c_q.cnt == LAST_BIT) begin
                        if (c_q.st == ST_RXDEV) begin
                            if (c_q.sh[DW-1 -: 4] == DEV_PREFIX && !wr_busy) begin
                                c_d.pull = 1'b1;
                                if (c_q.sh[0]) begin
                                    c_d.st   = ST_TX;
                                    c_d.mack = 1'b1;
                                end else begin
                                    c_d.st = ST_RXWORD;
                                    c_d.ptr[AW-1 -: HI_BITS] = c_q.sh[HI_BITS:1];
                                end
                            end else begin
                                c_d.st = ST_HOLD;
                            end
                        end else if (c_q.st == ST_RXWORD) begin
                            c_d.pull         = 1'b1;
                            c_d.ptr[DW-1:0]  = c_q.sh;
                            c_d.st           = ST_RXDATA;
                        end else begin
                            c_d.pull  = 1'b1;
                            c_d.wreq  = 1'b1;
                            c_d.waddr = c_q.ptr;
                            c_d.wdata = c_q.sh;
                            c_d.pend  = 1'b1;
                            c_d.ptr[PAGE_BITS-1:0] = c_q.ptr[PAGE_BITS-1:0] + 1'b1;
                        end
                    end
                end
                ST_TX: begin
                    if (c_q.cnt == ACK_END) begin
                        if (c_q.mack) begin
                            c_d.tx   = mem_rdata;
                            c_d.pull = ~mem_rdata[DW-1];
                            c_d.ptr  = c_q.ptr + 1'b1;
                            c_d.cnt  = '0;
                        end else begin
                            c_d.pull = 1'b0;
                            c_d.st   = ST_HOLD;
                        end
                    end else if (c_q.cnt == LAST_BIT) begin
                        c_d.pull = 1'b0;
                    end else if (c_q.cnt != '0) begin
                        c_d.tx   = c_q.tx << 1;
                        c_d.pull = ~c_q.tx[DW-2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_pull  = c_q.pull;
    assign mem_raddr = c_q.ptr;
    assign wr_req    = c_q.wreq;
    assign wr_addr   = c_q.waddr;
    assign wr_data   = c_q.wdata;
    assign wr_commit = c_q.commit;
    assign st        = c_q.st;
endmodule

// File: rtl/i2c_eeprom_slave_fe.sv
module i2c_eeprom_slave_fe
    import i2c_ee_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 8,
    parameter int PAGE_BITS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          wr_busy,
    input  logic [DW-1:0] mem_rdata,
    output logic          sda_pull,
    output logic [AW-1:0] mem_raddr,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_commit
);
    logic      scl_rise, scl_fall, bus_start, bus_stop, sda_bit;
    ee_state_e ctrl_st;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_bit   (sda_bit)
    );

    i2c_ee_ctrl #(.AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_bit   (sda_bit),
        .wr_busy   (wr_busy),
        .mem_rdata (mem_rdata),
        .sda_pull  (sda_pull),
        .mem_raddr (mem_raddr),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .st        (ctrl_st)
    );
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
    import i2c_ee_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_in,
    input logic      sda_pull,
    input logic      wr_busy,
    input logic      wr_req,
    input logic      wr_commit,
    input logic      line_start,
    input logic      line_stop,
    input ee_state_e st
);
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_in);  // R12

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) && $past(st) == ST_RXDEV) |-> !$past(wr_busy));  // R11

    AST_WREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);  // R4

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(line_stop));  // R6

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_start) |-> !sda_pull);  // R2

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !sda_pull);  // R10
endmodule

bind i2c_eeprom_slave_fe i2c_ee_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_pull   (sda_pull),
    .wr_busy    (wr_busy),
    .wr_req     (wr_req),
    .wr_commit  (wr_commit),
    .line_start (bus_start),
    .line_stop  (bus_stop),
    .st         (ctrl_st)
);

// File: tb/sim_i2c_eeprom_slave_fe.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave_fe;
    localparam int Q    = 10;
    localparam int BUSY = 600;
    localparam logic [18:0] VEC [4] = '{
        {11'h000, 8'h5A}, {11'h3FF, 8'hC3}, {11'h400, 8'h01}, {11'h7A5, 8'hFE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic wr_busy;
    logic [7:0] mem_rdata;
    logic sda_pull, wr_req, wr_commit;
    logic [10:0] mem_raddr, wr_addr;
    logic [7:0] wr_data;

    logic [7:0]  mem     [2048];
    logic [7:0]  exp_mem [2048];
    logic [10:0] pb_a [32];
    logic [7:0]  pb_d [32];
    int pb_n = 0;
    int commits = 0;
    int busy_cnt = 0;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign wr_busy   = (busy_cnt != 0);
    assign mem_rdata = mem[mem_raddr];

    i2c_eeprom_slave_fe u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .wr_busy(wr_busy), .mem_rdata(mem_rdata), .sda_pull(sda_pull),
        .mem_raddr(mem_raddr), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit)
    );

    // Page buffer and array model behind the engine.
    always @(posedge clk) begin
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (wr_req && pb_n < 32) begin
            pb_a[pb_n] <= wr_addr;
            pb_d[pb_n] <= wr_data;
            pb_n <= pb_n + 1;
        end
        if (wr_commit) begin
            for (int k = 0; k < pb_n; k++) mem[pb_a[k]] <= pb_d[k];
            pb_n <= 0;
            commits <= commits + 1;
            busy_cnt <= BUSY;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic r, output logic steady);
        logic a;
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(3); a = sda_line; tick(Q - 3); r = sda_line;
        scl_m = 1'b0; tick(Q);
        steady = (a == r);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r, s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r, s);
        clk_bit(1'b1, r, s);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b, output logic steady);
        logic r, s;
        steady = 1'b1;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r, s);
            b = {b[6:0], r};
            steady &= s;
        end
        clk_bit(~mack, r, s);
    endtask

    task automatic poll_ready(input logic [2:0] hi, output int tries, output logic ok);
        logic ack;
        ok = 1'b0;
        tries = 0;
        while (!ok && tries < 20) begin
            bus_start;
            send_byte({4'hA, hi, 1'b0}, ack);
            bus_stop;
            tries++;
            ok = ack;
        end
    endtask

    task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
        logic ack, s;
        bus_start;
        send_byte({4'hA, a[10:8], 1'b0}, ack);
        send_byte(a[7:0], ack);
        bus_start;
        send_byte(8'hA1, ack);
        recv_byte(1'b0, d, s);
        bus_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic ack, ok, s;
        logic [7:0] d;
        int tries, c0;
        for (int i = 0; i < 2048; i++) begin
            mem[i]     = 8'(i * 37 + (i >> 5));
            exp_mem[i] = 8'(i * 37 + (i >> 5));
        end
        tick(5);
        check_eq("R1 pull in reset", int'(sda_pull), 0);
        rst_n = 1'b1;
        tick(3);
        check_eq("R1 pull after reset", int'(sda_pull), 0);
        check_eq("R1 strobes after reset", int'({wr_req, wr_commit}), 0);

        // Vector table: byte write, poll, random read back.
        for (int v = 0; v < 4; v++) begin
            logic [10:0] a;
            logic [7:0]  dv;
            a = VEC[v][18:8];
            dv = VEC[v][7:0];
            c0 = commits;
            bus_start;
            send_byte({4'hA, a[10:8], 1'b0}, ack);
            check_eq("R3 dev ack", int'(ack), 1);
            send_byte(a[7:0], ack);
            check_eq("R4 word ack", int'(ack), 1);
            send_byte(dv, ack);
            check_eq("R4 data ack", int'(ack), 1);
            check_eq("R4 wr_addr", int'(pb_a[0]), int'(a));
            check_eq("R4 wr_data", int'(pb_d[0]), int'(dv));
            bus_stop;
            tick(2);
            check_eq("R6 commit count", commits, c0 + 1);
            exp_mem[a] = dv;
            poll_ready(a[10:8], tries, ok);
            rand_read(a, d);
            check_eq("R8 random read", int'(d), int'(exp_mem[a]));
        end

        // R3: wrong prefix is refused and the rest of the transfer ignored.
        bus_start;
        send_byte(8'hB0, ack);
        check_eq("R3 bad prefix nack", int'(ack), 0);
        send_byte(8'h00, ack);
        check_eq("R3 ignored after mismatch", int'(ack), 0);
        bus_stop;

        // R11: acknowledge polling.
        bus_start;
        send_byte(8'hA2, ack);
        send_byte(8'h23, ack);
        send_byte(8'h77, ack);
        bus_stop;
        exp_mem[11'h123] = 8'h77;
        bus_start;
        send_byte(8'hA2, ack);
        bus_stop;
        check_eq("R11 busy nack", int'(ack), 0);
        poll_ready(3'd1, tries, ok);
        check_eq("R11 ack when idle", int'(ok), 1);

        // R5: page write wraps inside the 16-byte page.
        bus_start;
        send_byte(8'hA6, ack);
        send_byte(8'h1E, ack);
        for (int k = 0; k < 4; k++) send_byte(8'h10 + 8'(k), ack);
        check_eq("R5 page addr 0", int'(pb_a[0]), 'h31E);
        check_eq("R5 page addr 1", int'(pb_a[1]), 'h31F);
        check_eq("R5 page addr 2", int'(pb_a[2]), 'h310);
        check_eq("R5 page addr 3", int'(pb_a[3]), 'h311);
        bus_stop;
        exp_mem[11'h31E] = 8'h10; exp_mem[11'h31F] = 8'h11;
        exp_mem[11'h310] = 8'h12; exp_mem[11'h311] = 8'h13;
        poll_ready(3'd3, tries, ok);

        // R7: current-address reads, slave-byte upper bits ignored.
        bus_start;
        send_byte(8'hAF, ack);
        recv_byte(1'b0, d, s);
        bus_stop;
        check_eq("R7 current after write", int'(d), int'(exp_mem[11'h312]));
        bus_start;
        send_byte(8'hA1, ack);
        recv_byte(1'b0, d, s);
        bus_stop;
        check_eq("R7 current after read", int'(d), int'(exp_mem[11'h313]));
        rand_read(11'h310, d);
        check_eq("R5 wrapped byte stored", int'(d), 8'h12);

        // R9 / R10 / R12: sequential read across the top of the array.
        bus_start;
        send_byte(8'hAE, ack);
        send_byte(8'hFE, ack);
        bus_start;
        send_byte(8'hA1, ack);
        recv_byte(1'b1, d, s);
        check_eq("R9 seq byte 7FE", int'(d), int'(exp_mem[11'h7FE]));
        check_eq("R12 stable while SCL high", int'(s), 1);
        recv_byte(1'b1, d, s);
        check_eq("R9 seq byte 7FF", int'(d), int'(exp_mem[11'h7FF]));
        recv_byte(1'b0, d, s);
        check_eq("R9 seq wrap to 000", int'(d), int'(exp_mem[11'h000]));
        recv_byte(1'b0, d, s);
        check_eq("R10 released after nack", int'(d), 8'hFF);
        bus_stop;

        // R2: repeated START in the middle of a data byte.
        c0 = commits;
        bus_start;
        send_byte(8'hA0, ack);
        send_byte(8'h50, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, ok, s);
        bus_start;
        send_byte(8'hA1, ack);
        check_eq("R2 address after abort", int'(ack), 1);
        recv_byte(1'b0, d, s);
        bus_stop;
        check_eq("R2 read after abort", int'(d), int'(exp_mem[11'h050]));
        tick(2);
        check_eq("R2 no write request", pb_n, 0);
        check_eq("R2 no commit", commits, c0);

        // R6: STOP after only a word address commits nothing.
        bus_start;
        send_byte(8'hA0, ack);
        send_byte(8'h20, ack);
        bus_stop;
        tick(2);
        check_eq("R6 no commit without data", commits, c0);
        check_eq("R6 not busy", int'(wr_busy), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule